// File: doc/BRIEF.md
# Accumulator ALU with Selective Flag Update

This block is the arithmetic and logic unit of a small accumulator-style microcontroller core. For each executed instruction it takes the working-register value W and a second operand, either the addressed file location F or an immediate literal K. An operation code picks one of fourteen operations. The unit returns a registered result and two write strobes, one for W and one for the file location. It also keeps a three-bit flag register holding carry (C), digit carry (DC) and zero (Z).

Each operation has its own flag mask. Only the flags in that mask change, and the other flags keep their old values. Rotates move the operand one place through the stored carry. Subtraction always computes the second operand minus W. The nibble swap changes no flag.

The instruction executor pulses `exec_i` for one cycle per instruction. It then uses `res_o` together with `wr_w_o` or `wr_f_o` in the following cycle. Instruction decode, the register file and branch or skip control all sit outside this block.

Top module: `acc_alu_core`

## Requirements
- R1: While reset is asserted and after it is released, with no instruction executed, `res_o`, both write strobes and all three flags read 0.
- R2: Op code 0 (add) gives result (B+W) mod 256, where B is K when `lit_i`=1 and F otherwise. C takes the ninth sum bit, DC is set when the low four bits carry out, and Z is set when the result is zero.
- R3: Op code 1 (subtract) gives result (B−W) mod 256. C is 1 when B≥W (no borrow), DC is 1 when B[3:0]≥W[3:0], and Z is set when the result is zero.
- R4: Op codes 2 (AND), 3 (OR), 4 (XOR) and 7 (complement of B) update only Z, from the result. Op code 9 (move B) with `lit_i`=0 also updates only Z. C and DC keep their old values.
- R5: Op codes 5 (B+1) and 6 (B−1) wrap modulo 256 and update only Z.
- R6: Op code 8 (clear) gives result 0 and sets Z to 1. C and DC keep their old values.
- R7: Op code 10 (swap) gives {B[3:0],B[7:4]} and leaves all three flags unchanged.
- R8: Op code 11 (rotate left) gives {B[6:0],C} with new C=B[7]. Op code 12 (rotate right) gives {C,B[7:1]} with new C=B[0]. Rotates change only C.
- R9: The result is written to the file location (`wr_f_o`=1) when `dest_f_i`=1 and `lit_i`=0. In every other case it goes to W (`wr_w_o`=1). The two strobes are never high together.
- R10: Results, strobes and flags take effect in the cycle after an edge with `exec_i`=1. With `exec_i`=0 the strobes read 0, and `res_o` and the flags keep their values.
- R11: Op code 13 (move W) gives result W, and op code 9 with `lit_i`=1 (load literal) gives result K. Neither one changes any flag.
- R12: Op codes 14 and 15 raise no write strobe, give result 0 and leave all flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| exec_i | input | 1 | Execute strobe, one cycle per instruction |
| op_i | input | 4 | Operation code |
| lit_i | input | 1 | 1: second operand is K and the destination is W |
| dest_f_i | input | 1 | 1: write the result to the file location (file forms only) |
| w_i | input | DATA_W | Working-register operand |
| f_i | input | DATA_W | File-location operand |
| k_i | input | DATA_W | Literal operand |
| res_o | output | DATA_W | Registered result |
| wr_w_o | output | 1 | Write strobe for W |
| wr_f_o | output | 1 | Write strobe for the file location |
| c_o | output | 1 | Carry / not-borrow flag |
| dc_o | output | 1 | Digit carry / not-nibble-borrow flag |
| z_o | output | 1 | Zero flag |

## Verification
The bench builds the block at its default 8-bit width. At that width the full 256×256 operand space of both add and subtract can be covered in one run, so every combination of carry, digit carry and zero is reached, including the exact B=W and nibble-equal borrow boundaries. The other operations are swept over all 256 operand values with the stored carry chained from one step to the next. This shows that rotates pick up the prior carry and that masked flags survive across unrelated operations.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_AND  = 4'd2,
    OP_IOR  = 4'd3,
    OP_XOR  = 4'd4,
    OP_INC  = 4'd5,
    OP_DEC  = 4'd6,
    OP_COM  = 4'd7,
    OP_CLR  = 4'd8,
    OP_MOV  = 4'd9,
    OP_SWAP = 4'd10,
    OP_RL   = 4'd11,
    OP_RR   = 4'd12,
    OP_MVW  = 4'd13,
    OP_RS14 = 4'd14,
    OP_RS15 = 4'd15
  } alu_op_e;

  // flag bundle, carry in the top bit
  typedef struct packed {
    logic c;
    logic dc;
    logic z;
  } alu_flags_t;

  localparam int NUM_FLAGS = 3;

endpackage

// File: rtl/acc_alu_datapath.sv
module acc_alu_datapath
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  alu_op_e           op,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic [DATA_W-1:0] opnd_w,
  input  logic              c_in,
  output logic [DATA_W-1:0] res,
  output alu_flags_t        raw
);

  localparam int NIB_W = DATA_W / 2;
  localparam logic [DATA_W:0] ONE_FULL = {{DATA_W{1'b0}}, 1'b1};
  localparam logic [NIB_W:0]  ONE_NIB  = {{NIB_W{1'b0}}, 1'b1};
  localparam logic [DATA_W-1:0] ONE_D  = {{(DATA_W-1){1'b0}}, 1'b1};

  logic [DATA_W:0] sum_full;
  logic [DATA_W:0] dif_full;
  logic [NIB_W:0]  sum_nib;
  logic [NIB_W:0]  dif_nib;
  logic [DATA_W-1:0] swapped;

  // top bit of each adder is carry out; for the difference it is not-borrow
  always_comb begin
    sum_full = {1'b0, opnd_b} + {1'b0, opnd_w};
    dif_full = {1'b0, opnd_b} + {1'b0, ~opnd_w} + ONE_FULL;
    sum_nib  = {1'b0, opnd_b[NIB_W-1:0]} + {1'b0, opnd_w[NIB_W-1:0]};
    dif_nib  = {1'b0, opnd_b[NIB_W-1:0]} + {1'b0, ~opnd_w[NIB_W-1:0]} + ONE_NIB;
  end

  // half exchange; an odd width keeps its middle bit in place
  generate
    if (DATA_W % 2 == 0) begin : g_even_swap
      assign swapped = {opnd_b[NIB_W-1:0], opnd_b[DATA_W-1:NIB_W]};
    end else begin : g_odd_swap
      assign swapped = {opnd_b[NIB_W-1:0], opnd_b[NIB_W], opnd_b[DATA_W-1:NIB_W+1]};
    end
  endgenerate

  always_comb begin
    res    = '0;
    raw.c  = c_in;
    raw.dc = 1'b0;
    unique case (op)
      OP_ADD: begin
        res    = sum_full[DATA_W-1:0];
        raw.c  = sum_full[DATA_W];
        raw.dc = sum_nib[NIB_W];
      end
      OP_SUB: begin
        res    = dif_full[DATA_W-1:0];
        raw.c  = dif_full[DATA_W];
        raw.dc = dif_nib[NIB_W];
      end
      OP_AND:  res = opnd_b & opnd_w;
      OP_IOR:  res = opnd_b | opnd_w;
      OP_XOR:  res = opnd_b ^ opnd_w;
      OP_INC:  res = opnd_b + ONE_D;
      OP_DEC:  res = opnd_b - ONE_D;
      OP_COM:  res = ~opnd_b;
      OP_CLR:  res = '0;
      OP_MOV:  res = opnd_b;
      OP_SWAP: res = swapped;
      OP_RL: begin
        res   = {opnd_b[DATA_W-2:0], c_in};
        raw.c = opnd_b[DATA_W-1];
      end
      OP_RR: begin
        res   = {c_in, opnd_b[DATA_W-1:1]};
        raw.c = opnd_b[0];
      end
      OP_MVW:  res = opnd_w;
      default: res = '0;
    endcase
    raw.z = (res == '0);
  end

endmodule

// File: rtl/acc_alu_decode.sv
module acc_alu_decode
  import acc_alu_pkg::*;
(
  input  alu_op_e    op,
  input  logic       lit,
  input  logic       dest_f,
  output alu_flags_t mask,
  output logic       to_w,
  output logic       to_f
);

  logic valid_op;

  always_comb begin
    mask     = '0;
    valid_op = 1'b1;
    unique case (op)
      OP_ADD, OP_SUB:                  mask = '{c: 1'b1, dc: 1'b1, z: 1'b1};
      OP_AND, OP_IOR, OP_XOR, OP_COM,
      OP_INC, OP_DEC, OP_CLR:          mask = '{c: 1'b0, dc: 1'b0, z: 1'b1};
      OP_MOV:                          mask = '{c: 1'b0, dc: 1'b0, z: ~lit};
      OP_RL, OP_RR:                    mask = '{c: 1'b1, dc: 1'b0, z: 1'b0};
      OP_SWAP, OP_MVW:                 mask = '0;
      default: begin
        mask     = '0;
        valid_op = 1'b0;
      end
    endcase
  end

  // literal forms always land in W
  always_comb begin
    to_f = valid_op & dest_f & ~lit;
    to_w = valid_op & ~to_f;
  end

endmodule

// File: rtl/acc_alu_flags.sv
module acc_alu_flags #(
  parameter int NFLAG = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [NFLAG-1:0] mask,
  input  logic [NFLAG-1:0] raw,
  output logic [NFLAG-1:0] q
);

  logic [NFLAG-1:0] flag_q;
  logic [NFLAG-1:0] flag_d;

  generate
    for (genvar i = 0; i < NFLAG; i++) begin : g_bit
      always_comb begin
        flag_d[i] = (en && mask[i]) ? raw[i] : flag_q[i];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q[i] <= 1'b0;
        else        flag_q[i] <= flag_d[i];
      end
    end
  endgenerate

  assign q = flag_q;

  assert_flags_hold_idle_R10: assert property (
    @(posedge clk) disable iff (!rst_n)
    !en |=> $stable(flag_q));

  assert_unmasked_hold_R4: assert property (
    @(posedge clk) disable iff (!rst_n)
    (en && mask == '0) |=> $stable(flag_q));

endmodule

// File: rtl/acc_alu_core.sv
module acc_alu_core
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exec_i,
  input  logic [3:0]        op_i,
  input  logic              lit_i,
  input  logic              dest_f_i,
  input  logic [DATA_W-1:0] w_i,
  input  logic [DATA_W-1:0] f_i,
  input  logic [DATA_W-1:0] k_i,
  output logic [DATA_W-1:0] res_o,
  output logic              wr_w_o,
  output logic              wr_f_o,
  output logic              c_o,
  output logic              dc_o,
  output logic              z_o
);

  // reset: asserted at once, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q_n = rst_pipe[1];

  alu_op_e           op;
  logic [DATA_W-1:0] opnd_b;
  logic [DATA_W-1:0] dp_res;
  alu_flags_t        dp_raw;
  alu_flags_t        mask;
  alu_flags_t        flags_q;
  logic              to_w;
  logic              to_f;

  assign op     = alu_op_e'(op_i);
  assign opnd_b = lit_i ? k_i : f_i;

  acc_alu_datapath #(.DATA_W(DATA_W)) i_datapath (
    .op     (op),
    .opnd_b (opnd_b),
    .opnd_w (w_i),
    .c_in   (flags_q.c),
    .res    (dp_res),
    .raw    (dp_raw)
  );

  acc_alu_decode i_decode (
    .op     (op),
    .lit    (lit_i),
    .dest_f (dest_f_i),
    .mask   (mask),
    .to_w   (to_w),
    .to_f   (to_f)
  );

  acc_alu_flags #(.NFLAG(NUM_FLAGS)) i_flags (
    .clk   (clk),
    .rst_n (rst_q_n),
    .en    (exec_i),
    .mask  (mask),
    .raw   (dp_raw),
    .q     (flags_q)
  );

  // result and strobe registers
  logic [DATA_W-1:0] res_q,  res_d;
  logic              ww_q,   ww_d;
  logic              wf_q,   wf_d;

  always_comb begin
    res_d = exec_i ? dp_res : res_q;
    ww_d  = exec_i & to_w;
    wf_d  = exec_i & to_f;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      res_q <= '0;
      ww_q  <= 1'b0;
      wf_q  <= 1'b0;
    end else begin
      res_q <= res_d;
      ww_q  <= ww_d;
      wf_q  <= wf_d;
    end
  end

  assign res_o  = res_q;
  assign wr_w_o = ww_q;
  assign wr_f_o = wf_q;
  assign c_o    = flags_q.c;
  assign dc_o   = flags_q.dc;
  assign z_o    = flags_q.z;

  assert_single_dest_R9: assert property (
    @(posedge clk) disable iff (!rst_q_n)
    !(wr_w_o && wr_f_o));

  assert_literal_to_w_R9: assert property (
    @(posedge clk) disable iff (!rst_q_n)
    (exec_i && lit_i && op_i <= 4'd13) |=> (wr_w_o && !wr_f_o));

  assert_idle_no_strobe_R10: assert property (
    @(posedge clk) disable iff (!rst_q_n)
    !exec_i |=> (!wr_w_o && !wr_f_o && $stable(res_o)));

  assert_sub_not_borrow_R3: assert property (
    @(posedge clk) disable iff (!rst_q_n)
    (exec_i && op_i == OP_SUB) |=> (c_o == ($past(opnd_b) >= $past(w_i))));

  assert_clear_zero_R6: assert property (
    @(posedge clk) disable iff (!rst_q_n)
    (exec_i && op_i == OP_CLR) |=> (res_o == '0 && z_o));

  assert_swap_keeps_flags_R7: assert property (
    @(posedge clk) disable iff (!rst_q_n)
    (exec_i && op_i == OP_SWAP) |=> $stable({c_o, dc_o, z_o}));

  assert_rotl_carry_out_R8: assert property (
    @(posedge clk) disable iff (!rst_q_n)
    (exec_i && op_i == OP_RL) |=> (c_o == $past(opnd_b[DATA_W-1])));

  assert_undef_no_write_R12: assert property (
    @(posedge clk) disable iff (!rst_q_n)
    (exec_i && op_i >= 4'd14) |=> (!wr_w_o && !wr_f_o && $stable({c_o, dc_o, z_o})));

endmodule

// File: tb/test_acc_alu_core.sv
`timescale 1ns/1ps
module test_acc_alu_core;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       exec_i;
  logic [3:0] op_i;
  logic       lit_i;
  logic       dest_f_i;
  logic [7:0] w_i, f_i, k_i;
  logic [7:0] res_o;
  logic       wr_w_o, wr_f_o, c_o, dc_o, z_o;

  always #10 clk = ~clk;  // 50 MHz

  acc_alu_core #(.DATA_W(8)) i_acc_alu_core (
    .clk(clk), .rst_n(rst_n), .exec_i(exec_i), .op_i(op_i), .lit_i(lit_i),
    .dest_f_i(dest_f_i), .w_i(w_i), .f_i(f_i), .k_i(k_i), .res_o(res_o),
    .wr_w_o(wr_w_o), .wr_f_o(wr_f_o), .c_o(c_o), .dc_o(dc_o), .z_o(z_o)
  );

  typedef struct {
    logic [7:0] res;
    logic       ww, wf, c, dc, z;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   n_checks = 0;
  int   n_fail   = 0;
  logic done     = 1'b0;

  // reference state built from the requirements
  logic [7:0] m_res = 8'h00;
  logic       m_c = 1'b0, m_dc = 1'b0, m_z = 1'b0;

  task automatic step(input logic ex, input logic [3:0] op, input logic lit,
                      input logic dst, input logic [7:0] w, input logic [7:0] f,
                      input logic [7:0] k);
    exp_t e;
    logic [7:0] b, r;
    logic [8:0] s;
    logic ww, wf, valid;
    string t;
    exec_i = ex; op_i = op; lit_i = lit; dest_f_i = dst;
    w_i = w; f_i = f; k_i = k;
    ww = 1'b0; wf = 1'b0;
    t = "R10";
    if (ex) begin
      b = lit ? k : f;
      r = 8'h00;
      valid = (op <= 4'd13);
      case (op)
        4'd0: begin s = {1'b0, b} + {1'b0, w}; r = s[7:0]; m_c = s[8];
                m_dc = ({1'b0, b[3:0]} + {1'b0, w[3:0]}) > 5'd15; m_z = (r == 0); t = "R2"; end
        4'd1: begin r = b - w; m_c = (b >= w); m_dc = (b[3:0] >= w[3:0]); m_z = (r == 0); t = "R3"; end
        4'd2: begin r = b & w; m_z = (r == 0); t = "R4"; end
        4'd3: begin r = b | w; m_z = (r == 0); t = "R4"; end
        4'd4: begin r = b ^ w; m_z = (r == 0); t = "R4"; end
        4'd5: begin r = b + 8'd1; m_z = (r == 0); t = "R5"; end
        4'd6: begin r = b - 8'd1; m_z = (r == 0); t = "R5"; end
        4'd7: begin r = ~b; m_z = (r == 0); t = "R4"; end
        4'd8: begin r = 8'h00; m_z = 1'b1; t = "R6"; end
        4'd9: begin r = b; if (!lit) begin m_z = (r == 0); t = "R4"; end else t = "R11"; end
        4'd10: begin r = {b[3:0], b[7:4]}; t = "R7"; end
        4'd11: begin r = {b[6:0], m_c}; m_c = b[7]; t = "R8"; end
        4'd12: begin r = {m_c, b[7:1]}; m_c = b[0]; t = "R8"; end
        4'd13: begin r = w; t = "R11"; end
        default: begin r = 8'h00; t = "R12"; end
      endcase
      m_res = r;
      wf = valid && dst && !lit;
      ww = valid && !wf;
      t = {t, "/R9"};
    end
    e.res = m_res; e.ww = ww; e.wf = wf; e.c = m_c; e.dc = m_dc; e.z = m_z; e.tag = t;
    q.push_back(e);
    @(negedge clk);
  endtask

  // monitor: outputs sampled mid-way between the capturing edge and the next drive
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        n_checks++;
        if (res_o !== e.res || wr_w_o !== e.ww || wr_f_o !== e.wf ||
            c_o !== e.c || dc_o !== e.dc || z_o !== e.z) begin
          n_fail++;
          $display("FAIL %s: got res=%02h ww=%0b wf=%0b c=%0b dc=%0b z=%0b, expected res=%02h ww=%0b wf=%0b c=%0b dc=%0b z=%0b",
                   e.tag, res_o, wr_w_o, wr_f_o, c_o, dc_o, z_o,
                   e.res, e.ww, e.wf, e.c, e.dc, e.z);
        end
      end
    end
  end

  task automatic check_reset(input string when_s);
    n_checks++;
    if (res_o !== 8'h00 || wr_w_o !== 1'b0 || wr_f_o !== 1'b0 ||
        c_o !== 1'b0 || dc_o !== 1'b0 || z_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 (%s): got res=%02h ww=%0b wf=%0b c=%0b dc=%0b z=%0b, expected all 0",
               when_s, res_o, wr_w_o, wr_f_o, c_o, dc_o, z_o);
    end
  endtask

  initial begin
    rst_n = 1'b0; exec_i = 1'b0; op_i = '0; lit_i = 1'b0; dest_f_i = 1'b0;
    w_i = '0; f_i = '0; k_i = '0;
    repeat (3) @(negedge clk);
    check_reset("during reset");  // R1
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_reset("after release"); // R1

    // R2: add over the full operand space, destination alternating (R9)
    for (int a = 0; a < 256; a++)
      for (int w = 0; w < 256; w++)
        step(1'b1, 4'd0, 1'b0, w[0] ^ a[0], w[7:0], a[7:0], 8'h00);
    // R3: subtract over the full operand space
    for (int a = 0; a < 256; a++)
      for (int w = 0; w < 256; w++)
        step(1'b1, 4'd1, 1'b0, w[1], w[7:0], a[7:0], 8'h00);

    // R4..R8, R11: every other op over all operand values, carry chained
    for (int op = 2; op <= 13; op++)
      for (int a = 0; a < 256; a++) begin
        logic [7:0] wv;
        wv = 8'(a * 37 + op * 11);
        step(1'b1, 4'(op), 1'b0, a[0], wv, a[7:0], 8'h5A);
        if (a % 64 == 0) step(1'b0, 4'(op), 1'b0, 1'b1, wv, 8'hFF, 8'hFF); // R10 idle
      end

    // literal forms: destination must be W even when dest_f_i=1 (R9, R11)
    for (int op = 0; op <= 13; op++)
      for (int a = 0; a < 32; a++)
        step(1'b1, 4'(op), 1'b1, 1'b1, 8'(a * 53), 8'hC3, 8'(a * 29 + 7));

    // R12: reserved op codes, after a step that leaves known flags
    for (int a = 0; a < 8; a++) begin
      step(1'b1, 4'd0, 1'b0, 1'b0, 8'hF8, 8'(a + 8), 8'h00);
      step(1'b1, 4'd14, 1'b0, 1'b1, 8'h00, 8'(a), 8'h00);
      step(1'b1, 4'd15, 1'b1, 1'b0, 8'h00, 8'(a), 8'h11);
    end

    step(1'b0, 4'd0, 1'b0, 1'b0, 8'h00, 8'h00, 8'h00);
    repeat (3) @(negedge clk);
    done = 1'b1;
  end

  initial begin
    for (int cyc = 0; cyc < 190000 && !done; cyc++) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion before 190000 cycles");
    end
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule